// File: doc/BRIEF.md
# Escape-coded extraction stream decoder

The decoder pulls 32-bit words from a switch CPU extraction queue and rebuilds one frame at a time. It waits for the queue's data-present flag and then throws away a configurable number of leading internal-header words. After that it reads the body, where words with the top bit set and the low three bits choosing an event act as in-band control codes. Plain words become payload. Depending on its value, a control code ends the frame, discards it, marks the following word as literal data, or is skipped as filler.

The recovered payload leaves on a valid/ready stream with a last flag and a byte-enable. When a frame finishes, a one-cycle done pulse carries a status of good, pruned or aborted and the byte count. A byte-order swap can be enabled, which reverses the four bytes of each word only for code matching. The payload always leaves unswapped. The decoder reads only while its single output register can take a word, so backpressure on the output stalls the queue reads.

Top module: `xtr_decoder`

## Requirements
- R1: While reset is held and in the cycle after it, out_valid, done and rd_en are low.
- R2: In idle, rd_en stays low. A frame starts one cycle after data_present is seen high in idle, and it does not start while data_present is low.
- R3: The first hdr_len words of a frame are consumed and not output. hdr_len = 0 sends the first word straight to body decoding.
- R4: A body word that is not a code (after the optional swap, not 0x80000000..0x80000007) is output with out_be = 4'b1111 and out_last = 0, and it adds 4 to the byte count.
- R5: A code 0x8000000k with k in 0..3 is not output. The next word is output with out_last = 1 and out_be = 4'b1111 >> k, where bit i enables byte lane i and lane 0 is bits 7:0. done then reports status 0 (good) and a byte count of 4 per earlier payload word plus 4 - k.
- R6: The code 0x80000006 is not output. The next word is output as ordinary payload (out_last = 0, 4 bytes counted) even if it has the form of a code.
- R7: The code 0x80000007 is consumed and dropped, with no output and no bytes counted.
- R8: The code 0x80000004 is not output. The next word is output with out_last = 1 and out_be = 4'b1111, and done reports status 1 (pruned) with done_bytes = 0.
- R9: The code 0x80000005 is not output. The next word is output with out_last = 1 and out_be = 4'b0000, and done reports status 2 (aborted) with done_bytes = 0.
- R10: With swap_en = 1, codes are matched against the byte-reversed word, while out_data carries the word exactly as read.
- R11: While out_valid = 1 and out_ready = 0, the output word, last and byte-enable hold and rd_en stays low.
- R12: A word consumed at a clock edge with rd_en high appears on the output after that edge. The done pulse lasts one cycle and coincides with the first cycle that the final word is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_len | input | HDR_W | Number of leading header words to drop; held stable while a frame is in progress |
| swap_en | input | 1 | Reverse the word's byte order before matching codes |
| data_present | input | 1 | Queue group 0 holds a frame |
| rd_en | output | 1 | Read strobe; rd_data is consumed at each edge where it is high |
| rd_data | input | 32 | Current queue word |
| out_valid | output | 1 | Payload word valid |
| out_ready | input | 1 | Sink accepts the payload word |
| out_data | output | 32 | Payload word, unswapped |
| out_last | output | 1 | Final word of the frame |
| out_be | output | 4 | Byte-lane enables for the word |
| done | output | 1 | One-cycle frame-complete pulse |
| done_status | output | 2 | 0 good, 1 pruned, 2 aborted |
| done_bytes | output | CNT_W | Byte count of a good frame, 0 otherwise |

## Verification
Every result is one register stage from its cause. rd_en follows state and out_ready in the same cycle. A payload word, last flag and byte-enable appear just after the edge that consumed the word. The done pulse appears at that same edge, and the first read of a frame comes two cycles after data_present rises in idle. The bench drives all inputs at the falling edge and advances a behavioural model one step per cycle from the inputs it applied and the word at the queue head. At the next falling edge it compares every output with the model, so each expectation is checked exactly in the cycle it becomes due.

// File: rtl/xtr_pkg.sv
// Shared types for the extraction stream decoder.
// Assumes 32-bit queue words with control codes in the top range.
package xtr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_BODY, ST_ESC, ST_EOF, ST_PRUNE, ST_ABORT
    } xtr_state_t;

    typedef enum logic [2:0] {
        K_DATA, K_EOF, K_PRUNE, K_ABORT, K_ESC, K_WAIT
    } word_kind_t;

    typedef enum logic [1:0] {
        FR_GOOD = 2'd0, FR_PRUNED = 2'd1, FR_ABORTED = 2'd2
    } frame_status_t;
endpackage

// File: rtl/xtr_classify.sv
// Classifies one queue word as payload or one of the control codes.
// Purely combinational; the byte swap affects matching only.
module xtr_classify
    import xtr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] word,
    input  logic         swap_en,
    output word_kind_t   kind,
    output logic [1:0]   tail_drop
);
    localparam int NB = W / 8;
    localparam logic [W-1:0] CODE_BASE = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] swapped;
    logic [W-1:0] cmp;
    logic         is_code;

    // Byte reversal built lane by lane
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign swapped[b*8 +: 8] = word[(NB-1-b)*8 +: 8];
    end

    assign cmp     = swap_en ? swapped : word;
    assign is_code = (cmp[W-1:3] == CODE_BASE[W-1:3]);

    // Decode the low three bits of a code word into an event kind
    always_comb begin
        kind      = K_DATA;
        tail_drop = cmp[1:0];
        if (is_code) begin
            case (cmp[2:0])
                3'd4:    kind = K_PRUNE;
                3'd5:    kind = K_ABORT;
                3'd6:    kind = K_ESC;
                3'd7:    kind = K_WAIT;
                default: kind = K_EOF;
            endcase
        end
    end
endmodule

// File: rtl/xtr_out_reg.sv
// Single output register for the payload stream with valid/ready.
// Assumes load is only raised when the register is empty or draining.
module xtr_out_reg #(
    parameter int W    = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [W-1:0]    d,
    input  logic            d_last,
    input  logic [BE_W-1:0] d_be,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [W-1:0]    out_data,
    output logic            out_last,
    output logic [BE_W-1:0] out_be
);
    // Hold or replace the presented word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
            out_be    <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= d;
            out_last  <= d_last;
            out_be    <= d_be;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_last) && $stable(out_be)));

    assert_full_be_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (out_be == {BE_W{1'b1}}));
endmodule

// File: rtl/xtr_ctrl.sv
// Frame sequencer: header skip, code handling, byte count and completion.
// Assumes hdr_len is stable for the duration of a frame.
module xtr_ctrl
    import xtr_pkg::*;
#(
    parameter int HDR_W = 4,
    parameter int CNT_W = 16,
    parameter int BE_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_present,
    input  logic [HDR_W-1:0] hdr_len,
    input  word_kind_t       kind,
    input  logic [1:0]       tail_drop,
    input  logic             out_valid,
    input  logic             out_ready,
    output logic             rd_en,
    output logic             load,
    output logic             load_last,
    output logic [BE_W-1:0]  load_be,
    output logic             done,
    output logic [1:0]       done_status,
    output logic [CNT_W-1:0] done_bytes
);
    localparam logic [CNT_W-1:0] WORD_BYTES = CNT_W'(BE_W);

    xtr_state_t       state, state_n;
    logic [HDR_W-1:0] hdr_cnt;
    logic [CNT_W-1:0] byte_cnt;
    logic [1:0]       drop_q;
    logic             finish;
    frame_status_t    fin_status;
    logic [CNT_W-1:0] fin_bytes;

    assign rd_en = (state != ST_IDLE) && (!out_valid || out_ready);

    // Next state and the word to load for the current read
    always_comb begin
        state_n    = state;
        load       = 1'b0;
        load_last  = 1'b0;
        load_be    = {BE_W{1'b1}};
        finish     = 1'b0;
        fin_status = FR_GOOD;
        fin_bytes  = '0;
        case (state)
            ST_IDLE: if (data_present) state_n = (hdr_len == '0) ? ST_BODY : ST_HDR;
            ST_HDR: if (rd_en && (HDR_W'(hdr_cnt + 1'b1) == hdr_len)) state_n = ST_BODY;
            ST_BODY: if (rd_en) begin
                case (kind)
                    K_DATA:  load = 1'b1;
                    K_EOF:   state_n = ST_EOF;
                    K_PRUNE: state_n = ST_PRUNE;
                    K_ABORT: state_n = ST_ABORT;
                    K_ESC:   state_n = ST_ESC;
                    default: ;
                endcase
            end
            ST_ESC: if (rd_en) begin
                load    = 1'b1;
                state_n = ST_BODY;
            end
            ST_EOF: if (rd_en) begin
                load      = 1'b1;
                load_last = 1'b1;
                load_be   = {BE_W{1'b1}} >> drop_q;
                finish    = 1'b1;
                fin_bytes = byte_cnt + WORD_BYTES - CNT_W'(drop_q);
                state_n   = ST_IDLE;
            end
            ST_PRUNE: if (rd_en) begin
                load       = 1'b1;
                load_last  = 1'b1;
                finish     = 1'b1;
                fin_status = FR_PRUNED;
                state_n    = ST_IDLE;
            end
            ST_ABORT: if (rd_en) begin
                load       = 1'b1;
                load_last  = 1'b1;
                load_be    = '0;
                finish     = 1'b1;
                fin_status = FR_ABORTED;
                state_n    = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State, header counter, saved tail code and running byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hdr_cnt  <= '0;
            drop_q   <= '0;
            byte_cnt <= '0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE) begin
                hdr_cnt  <= '0;
                byte_cnt <= '0;
            end else begin
                if (state == ST_HDR && rd_en) hdr_cnt <= hdr_cnt + 1'b1;
                if (load && !load_last) byte_cnt <= byte_cnt + WORD_BYTES;
            end
            if (state == ST_BODY && rd_en && kind == K_EOF) drop_q <= tail_drop;
        end
    end

    // Completion pulse with status and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            done_status <= '0;
            done_bytes  <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                done_status <= fin_status;
                done_bytes  <= fin_bytes;
            end
        end
    end

    assert_idle_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !data_present) |=> !rd_en);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_discard_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status != 2'd0) |-> (done_bytes == '0));
endmodule

// File: rtl/xtr_decoder.sv
// Top of the extraction stream decoder: classifier, sequencer, output stage.
// Assumes rd_data always holds a word while a frame is being read.
module xtr_decoder
    import xtr_pkg::*;
#(
    parameter int HDR_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HDR_W-1:0] hdr_len,
    input  logic             swap_en,
    input  logic             data_present,
    output logic             rd_en,
    input  logic [31:0]      rd_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_data,
    output logic             out_last,
    output logic [3:0]       out_be,
    output logic             done,
    output logic [1:0]       done_status,
    output logic [CNT_W-1:0] done_bytes
);
    localparam int W    = 32;
    localparam int BE_W = W / 8;

    word_kind_t      kind;
    logic [1:0]      tail_drop;
    logic            load, load_last;
    logic [BE_W-1:0] load_be;

    xtr_classify #(.W(W)) u_classify (
        .word(rd_data), .swap_en(swap_en), .kind(kind), .tail_drop(tail_drop)
    );

    xtr_ctrl #(.HDR_W(HDR_W), .CNT_W(CNT_W), .BE_W(BE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .data_present(data_present), .hdr_len(hdr_len),
        .kind(kind), .tail_drop(tail_drop), .out_valid(out_valid),
        .out_ready(out_ready), .rd_en(rd_en), .load(load), .load_last(load_last),
        .load_be(load_be), .done(done), .done_status(done_status),
        .done_bytes(done_bytes)
    );

    xtr_out_reg #(.W(W), .BE_W(BE_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(load), .d(rd_data), .d_last(load_last),
        .d_be(load_be), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .out_be(out_be)
    );

    assert_done_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && out_last));
endmodule

// File: tb/tb_xtr_decoder.sv
module tb_xtr_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  hdr_len = '0;
    logic        swap_en = 1'b0;
    logic        data_present = 1'b0;
    logic        rd_en;
    logic [31:0] rd_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_last;
    logic [3:0]  out_be;
    logic        done;
    logic [1:0]  done_status;
    logic [15:0] done_bytes;

    xtr_decoder dut (.*);

    always #4 clk = ~clk;

    int    n_vec = 0, n_bad = 0;
    string cur_req = "R1";
    logic [31:0] wq[$];
    bit    hold_dp = 0, ready_mode = 0, pend = 0;
    logic [7:0] lfsr = 8'hA5;
    int    ncnt = 0, frames = 0, beats = 0, last_stat = 0, last_bytes = 0;

    // reference model state
    int mst = 0, hcnt = 0, mbytes = 0, mdrop = 0;
    bit ev = 0, el = 0, ed = 0, erd = 0;
    logic [31:0] edata = '0;
    logic [3:0]  ebe = '0;
    int estat = 0, ebytes = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic emit(input logic [31:0] w, input bit l, input logic [3:0] be);
        ev = 1; edata = w; el = l; ebe = be;
    endtask

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // Per-cycle driver, reference model and comparison
    always @(negedge clk) begin
        logic [31:0] w, cw;
        ncnt++;
        if (ncnt > 150000) begin
            n_bad++;
            $display("FAIL R12 watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
        chk(out_valid === ev, cur_req, "out_valid", out_valid, ev);
        chk(done === ed, cur_req, "done", done, ed);
        if (ev) begin
            chk(out_data === edata, cur_req, "out_data", out_data, edata);
            chk(out_last === el, cur_req, "out_last", out_last, el);
            chk(out_be === ebe, cur_req, "out_be", out_be, ebe);
        end
        if (ed) begin
            chk(done_status === 2'(estat), cur_req, "done_status", done_status, estat);
            chk(done_bytes === 16'(ebytes), cur_req, "done_bytes", done_bytes, ebytes);
            frames++; last_stat = done_status; last_bytes = done_bytes;
        end
        if (pend && wq.size() > 0) void'(wq.pop_front());
        if (ncnt == 4) rst_n = 1'b1;
        out_ready = ready_mode ? lfsr[0] : 1'b1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        data_present = !hold_dp && wq.size() > 0;
        rd_data = (wq.size() > 0) ? wq[0] : 32'h8000_0007;
        #1;
        if (!rst_n) begin
            mst = 0; ev = 0; el = 0; ed = 0; edata = '0; ebe = '0;
            estat = 0; ebytes = 0; erd = 0;
        end else begin
            w = rd_data;
            cw = swap_en ? bswap(w) : w;
            erd = (mst != 0) && (!ev || out_ready);
            chk(rd_en === erd, cur_req, "rd_en", rd_en, erd);
            if (ev && out_ready) beats++;
            ed = 0;
            if (ev && out_ready) ev = 0;
            if (mst == 0) begin
                if (data_present) begin
                    mst = (hdr_len == 0) ? 2 : 1; hcnt = 0; mbytes = 0;
                end
            end else if (erd) begin
                case (mst)
                    1: begin hcnt++; if (hcnt == int'(hdr_len)) mst = 2; end
                    2: begin
                        if ((cw & 32'hFFFF_FFF8) == 32'h8000_0000) begin
                            case (cw[2:0])
                                3'd4: mst = 5;
                                3'd5: mst = 6;
                                3'd6: mst = 3;
                                3'd7: ;
                                default: begin mst = 4; mdrop = cw[1:0]; end
                            endcase
                        end else begin
                            emit(w, 0, 4'hF); mbytes += 4;
                        end
                    end
                    3: begin emit(w, 0, 4'hF); mbytes += 4; mst = 2; end
                    4: begin
                        emit(w, 1, 4'hF >> mdrop);
                        ed = 1; estat = 0; ebytes = mbytes + 4 - mdrop; mst = 0;
                    end
                    5: begin emit(w, 1, 4'hF); ed = 1; estat = 1; ebytes = 0; mst = 0; end
                    default: begin emit(w, 1, 4'h0); ed = 1; estat = 2; ebytes = 0; mst = 0; end
                endcase
            end
        end
        pend = rd_en;
    end

    task automatic finish_frame(input string req, input int xbeats,
                                input int xstat, input int xbytes);
        int f0, b0, t;
        f0 = frames; b0 = beats; t = 0;
        while (frames == f0 && t < 3000) begin @(posedge clk); t++; end
        repeat (4) @(posedge clk);
        chk(frames == f0 + 1, req, "frame completed", frames - f0, 1);
        chk(last_stat == xstat, req, "final status", last_stat, xstat);
        chk(last_bytes == xbytes, req, "final bytes", last_bytes, xbytes);
        chk(beats - b0 == xbeats, req, "payload beats", beats - b0, xbeats);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(out_valid === 1'b0 && done === 1'b0 && rd_en === 1'b0, "R1",
            "reset outputs", {out_valid, done, rd_en}, 0);
        repeat (4) @(posedge clk);

        // R3 R4 R5: two header words, payload, tail code k=1
        cur_req = "R5"; hdr_len = 4'd2; swap_en = 0;
        wq.push_back(32'hAAAA_0001); wq.push_back(32'hAAAA_0002);
        wq.push_back(32'h1111_1111); wq.push_back(32'h2222_2222);
        wq.push_back(32'h8000_0001); wq.push_back(32'h3333_3333);
        finish_frame("R3", 3, 0, 11);

        // R6 R7: no header, escaped code, filler words, tail code k=0
        cur_req = "R6"; hdr_len = 4'd0;
        wq.push_back(32'h0102_0304); wq.push_back(32'h8000_0006);
        wq.push_back(32'h8000_0000); wq.push_back(32'h8000_0007);
        wq.push_back(32'h8000_0007); wq.push_back(32'h0506_0708);
        wq.push_back(32'h8000_0000); wq.push_back(32'h0A0B_0C0D);
        finish_frame("R7", 4, 0, 16);

        // R8: pruned frame
        cur_req = "R8"; hdr_len = 4'd1;
        wq.push_back(32'hDEAD_0000); wq.push_back(32'h4444_4444);
        wq.push_back(32'h8000_0004); wq.push_back(32'h5555_5555);
        finish_frame("R8", 2, 1, 0);

        // R9: aborted frame
        cur_req = "R9";
        wq.push_back(32'hDEAD_0001); wq.push_back(32'h6666_6666);
        wq.push_back(32'h7777_7777); wq.push_back(32'h8000_0005);
        wq.push_back(32'h9999_9999);
        finish_frame("R9", 3, 2, 0);

        // R10: swapped matching, raw code-like word is payload
        cur_req = "R10"; hdr_len = 4'd0; swap_en = 1;
        wq.push_back(32'h8000_0001); wq.push_back(32'h0600_0080);
        wq.push_back(32'h0500_0080); wq.push_back(32'h0200_0080);
        wq.push_back(32'hCAFE_F00D);
        finish_frame("R10", 3, 0, 10);
        swap_en = 0;

        // R11: random backpressure, tail code k=3
        cur_req = "R11"; hdr_len = 4'd1; ready_mode = 1;
        wq.push_back(32'hBEEF_0000);
        for (int i = 0; i < 8; i++) wq.push_back(32'h1000_0000 + i);
        wq.push_back(32'h8000_0003); wq.push_back(32'hFACE_0001);
        finish_frame("R11", 9, 0, 33);
        ready_mode = 0;

        // R2 R12: no start while data_present is low, then tail code k=2
        cur_req = "R2"; hdr_len = 4'd0; hold_dp = 1;
        wq.push_back(32'h0000_ABCD); wq.push_back(32'h8000_0002);
        wq.push_back(32'h1234_5678);
        repeat (10) @(posedge clk);
        chk(wq.size() == 3 && frames == 6, "R2", "words held", wq.size(), 3);
        hold_dp = 0; cur_req = "R12";
        finish_frame("R12", 2, 0, 6);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule